// File: doc/BRIEF.md
# PLL Lock-Wait Timer Controller

This block sits in a clock generator next to a PLL. It holds a small control register with the PLL's mode setting, a bypass request and a choice of stabilization wait. It also counts reference-clock cycles after each PLL reconfiguration. Until the selected wait has elapsed it reports the PLL as not ready and keeps the clock selection on the reference clock. Once the count reaches its limit, the ready status rises and the selection follows the bypass request.

The wait length is 2^n − 2^8 + 1 reference cycles, where n is 11 + the wait-mode code. The block runs entirely on the reference clock and treats the PLL output only as a selection target. Its behaviour is an enumerated two-state machine:

- `ST_LOCKWAIT`: counting. Ready is low and the reference clock is forced.
- `ST_LOCKED`: the count is done. Ready is high and the counter is frozen.

It has three transitions:

- `LOCKWAIT→LOCKED`: the count has reached the limit of the current wait-mode.
- `LOCKED→LOCKWAIT`: a write changes the PLL mode field. This is the restart.
- `LOCKWAIT→LOCKWAIT` restart: a PLL mode change during a wait resets the count to zero.

Synchronous reset also enters `ST_LOCKWAIT` with the count at zero.

Top module: `pll_lockwait_ctrl`

## Requirements
- R1: While reset is held, the register reads back as follows: ready is 0, the wait-mode is binary 10, the PLL mode equals parameter PMODE_RST (default 5'h04), and the bypass bit equals the strap input. The clock select is 1.
- R2: After a restart, ready reads 0 for the first W−1 rising edges and 1 after the W-th. W = 2^(11+code) − 255, which gives 1793, 3841, 7937 or 16129 for codes 0 to 3. Reset release counts as a restart.
- R3: Register layout: PLL mode at bits 4:0, wait-mode at bits 6:5, bypass at bit 7, ready at bit 8. All other bits read 0, and the whole read data is 0 when read enable is low.
- R4: Write data bit 8 has no effect on the ready status.
- R5: A write whose PLL mode field differs from the stored value clears ready at that edge and restarts the count from zero.
- R6: While ready is 0, clk_sel_o is 1 (reference clock), whatever the bypass bit.
- R7: With ready at 1, a write that changes only the bypass bit moves clk_sel_o to the new bypass value right after that write's edge.
- R8: A single write that changes both bypass and PLL mode runs a full wait of W cycles on the reference clock. Only after that does clk_sel_o take the new bypass value.
- R9: Once ready is 1, it stays 1 until the next PLL mode change. Writes that keep the PLL mode unchanged never lower it.
- R10: A wait-mode change during a wait applies to the count in progress. If the count already exceeds the new limit, ready rises on the following edge.
- R11: pll_mode_o always equals the stored PLL mode field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_bypass_i | input | 1 | Reset value of the bypass bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| clk_sel_o | output | 1 | 1 selects the reference clock, 0 selects the PLL clock |
| pll_mode_o | output | 5 | PLL mode setting to the PLL |

## Verification
The bench samples the exact edge on which ready rises for every wait code. A counter that is off by one, or that uses the wrong exponent, moves that edge.

It drives a bypass release and a PLL mode change in the same write, and checks that the PLL clock is not selected before the wait ends. A design that honoured the bypass bit at once would switch onto an unlocked PLL.

It also shrinks the wait-mode in the middle of a count, and writes 1 to the ready bit while a wait is running. A latched limit or a writable status bit would then show up as a late or early ready.

Random register writes that leave the PLL mode untouched must never drop ready. They must also read back only the defined fields.

// File: rtl/pll_lw_pkg.sv
package pll_lw_pkg;

    localparam int PMODE_W   = 5;
    localparam int WMODE_W   = 2;
    localparam int PMODE_LSB = 0;
    localparam int WMODE_LSB = 5;
    localparam int BYP_BIT   = 7;
    localparam int RDY_BIT   = 8;

    localparam logic [WMODE_W-1:0] WMODE_RST = 2'b10;

    typedef enum logic [0:0] {
        ST_LOCKWAIT = 1'b0,
        ST_LOCKED   = 1'b1
    } lw_state_e;

endpackage

// File: rtl/pll_lw_limit.sv
module pll_lw_limit #(
    parameter int N_BASE = 11,
    parameter int M_EXP  = 8,
    parameter int CNT_W  = 14
) (
    input  logic [pll_lw_pkg::WMODE_W-1:0] wmode_i,
    output logic [CNT_W-1:0]               limit_o
);
    localparam int N_CODES = 1 << pll_lw_pkg::WMODE_W;

    logic [CNT_W-1:0] limit_tbl [N_CODES];

    for (genvar g = 0; g < N_CODES; g++) begin : g_lim
        localparam longint LEN = (64'd1 << (N_BASE + g)) - (64'd1 << M_EXP) + 64'd1;
        assign limit_tbl[g] = CNT_W'(LEN);
    end

    assign limit_o = limit_tbl[wmode_i];

endmodule

// File: rtl/pll_lw_regs.sv
module pll_lw_regs #(
    parameter logic [pll_lw_pkg::PMODE_W-1:0] PMODE_RST = 5'h04
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            strap_bypass_i,
    input  logic                            wr_en_i,
    input  logic                            wr_bypass_i,
    input  logic [pll_lw_pkg::WMODE_W-1:0]  wr_wmode_i,
    input  logic [pll_lw_pkg::PMODE_W-1:0]  wr_pmode_i,
    output logic                            bypass_o,
    output logic [pll_lw_pkg::WMODE_W-1:0]  wmode_o,
    output logic [pll_lw_pkg::PMODE_W-1:0]  pmode_o,
    output logic                            restart_o
);
    import pll_lw_pkg::*;

    logic               bypass_q;
    logic [WMODE_W-1:0] wmode_q;
    logic [PMODE_W-1:0] pmode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bypass_q <= strap_bypass_i;
            wmode_q  <= WMODE_RST;
            pmode_q  <= PMODE_RST;
        end else if (wr_en_i) begin
            bypass_q <= wr_bypass_i;
            wmode_q  <= wr_wmode_i;
            pmode_q  <= wr_pmode_i;
        end
    end

    // a changed PLL mode is a frequency change: the lock must be re-awaited
    assign restart_o = rst_n && wr_en_i && (wr_pmode_i != pmode_q);

    assign bypass_o = bypass_q;
    assign wmode_o  = wmode_q;
    assign pmode_o  = pmode_q;

    // R11
    pmode_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (pmode_o == $past(wr_pmode_i)));

endmodule

// File: rtl/pll_lw_fsm.sv
module pll_lw_fsm #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             ready_o
);
    import pll_lw_pkg::*;

    lw_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_limit;

    assign at_limit = (cnt_q >= (limit_i - CNT_W'(1)));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart_i) begin
            state_d = ST_LOCKWAIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_LOCKWAIT: begin
                    if (at_limit) state_d = ST_LOCKED;
                    else          cnt_d   = cnt_q + CNT_W'(1);
                end
                ST_LOCKED: begin
                    state_d = ST_LOCKED;
                end
                default: state_d = ST_LOCKWAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKWAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_LOCKED:   ready_o = 1'b1;
            ST_LOCKWAIT: ready_o = 1'b0;
            default:     ready_o = 1'b0;
        endcase
    end

    // R5
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!ready_o && cnt_q == '0));

    // R9
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !restart_i) |=> (ready_o && $stable(cnt_q)));

    // R2
    rise_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(cnt_q) >= $past(limit_i) - CNT_W'(1)));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !restart_i && !at_limit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/pll_lockwait_ctrl.sv
module pll_lockwait_ctrl #(
    parameter int                             DATA_W    = 32,
    parameter int                             N_BASE    = 11,
    parameter int                             M_EXP     = 8,
    parameter logic [pll_lw_pkg::PMODE_W-1:0] PMODE_RST = 5'h04
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           strap_bypass_i,
    input  logic                           wr_en_i,
    input  logic                           rd_en_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [DATA_W-1:0]              rdata_o,
    output logic                           clk_sel_o,
    output logic [pll_lw_pkg::PMODE_W-1:0] pll_mode_o
);
    import pll_lw_pkg::*;

    localparam int CNT_W = N_BASE + (1 << WMODE_W) - 1;

    logic               bypass;
    logic [WMODE_W-1:0] wmode;
    logic [PMODE_W-1:0] pmode;
    logic               restart;
    logic               ready;
    logic [CNT_W-1:0]   limit;
    logic               unused_wdata;

    assign unused_wdata = ^{wdata_i[DATA_W-1:BYP_BIT+1]};

    pll_lw_regs #(.PMODE_RST(PMODE_RST)) i_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_bypass_i (strap_bypass_i),
        .wr_en_i        (wr_en_i),
        .wr_bypass_i    (wdata_i[BYP_BIT]),
        .wr_wmode_i     (wdata_i[WMODE_LSB +: WMODE_W]),
        .wr_pmode_i     (wdata_i[PMODE_LSB +: PMODE_W]),
        .bypass_o       (bypass),
        .wmode_o        (wmode),
        .pmode_o        (pmode),
        .restart_o      (restart)
    );

    pll_lw_limit #(.N_BASE(N_BASE), .M_EXP(M_EXP), .CNT_W(CNT_W)) i_limit (
        .wmode_i (wmode),
        .limit_o (limit)
    );

    pll_lw_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .limit_i   (limit),
        .ready_o   (ready)
    );

    // the PLL clock is only selected once the lock wait is over
    assign clk_sel_o  = bypass | ~ready;
    assign pll_mode_o = pmode;

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            rdata_o[PMODE_LSB +: PMODE_W] = pmode;
            rdata_o[WMODE_LSB +: WMODE_W] = wmode;
            rdata_o[BYP_BIT]              = bypass;
            rdata_o[RDY_BIT]              = ready;
        end
    end

    // R8
    pll_change_refsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wdata_i[PMODE_LSB +: PMODE_W] != pll_mode_o) |=> clk_sel_o);

endmodule

// File: tb/test_pll_lockwait_ctrl.sv
module test_pll_lockwait_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        clk_sel;
    logic [4:0]  pll_mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pll_lockwait_ctrl i_pll_lockwait_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .strap_bypass_i (strap),
        .wr_en_i        (wr_en),
        .rd_en_i        (rd_en),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .clk_sel_o      (clk_sel),
        .pll_mode_o     (pll_mode)
    );

    function automatic int wait_len(input int code);
        return (1 << (11 + code)) - (1 << 8) + 1;
    endfunction

    function automatic logic [31:0] reg_word(input logic byp, input logic [1:0] wm,
                                             input logic [4:0] pm, input logic rdy);
        logic [31:0] w;
        w = '0;
        w[4:0] = pm;
        w[6:5] = wm;
        w[7]   = byp;
        w[8]   = rdy;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic rd(output logic [31:0] d);
        rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic chk_ready(input logic exp, input string req);
        logic [31:0] d;
        rd(d);
        check(d[8] === exp, req, {31'd0, d[8]}, {31'd0, exp});
    endtask

    task automatic chk_sel(input logic exp, input string req);
        check(clk_sel === exp, req, {31'd0, clk_sel}, {31'd0, exp});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, e;
        int w;
        logic byp;
        logic [1:0] wm;
        void'($urandom(32'h5EED_0042));

        // R1: reset state with strap high
        step(3);
        rd(d);
        e = reg_word(1'b1, 2'b10, 5'h04, 1'b0);
        check(d === e, "R1 reset readback", d, e);
        chk_sel(1'b1, "R1 reset clock select");
        check(pll_mode === 5'h04, "R11 reset pll mode", {27'd0, pll_mode}, 32'h4);

        // R3: read enable low gives zero
        #1;
        check(rdata === '0, "R3 idle read zero", rdata, 32'h0);

        // R2: reset release counts as restart, code 2
        rst_n = 1'b1;
        w = wait_len(2);
        step(w - 1);
        chk_ready(1'b0, "R2 code2 one edge early");
        step(1);
        chk_ready(1'b1, "R2 code2 at limit");

        // R7: bypass-only release with ready high
        wr(reg_word(1'b0, 2'b10, 5'h04, 1'b0));
        chk_sel(1'b0, "R7 bypass release immediate");
        chk_ready(1'b1, "R9 bypass write keeps ready");

        // R4: write 0 to ready bit while locked
        wr(reg_word(1'b0, 2'b10, 5'h04, 1'b0));
        chk_ready(1'b1, "R4 zero to ready ignored");

        // R5/R6: mode change, code 0, bypass 0
        wr(reg_word(1'b0, 2'b00, 5'h07, 1'b0));
        chk_ready(1'b0, "R5 ready cleared");
        chk_sel(1'b1, "R6 reference during wait");
        check(pll_mode === 5'h07, "R11 pll mode follows", {27'd0, pll_mode}, 32'h7);
        // R4: writing 1 to ready bit mid-wait does not set it
        wr(reg_word(1'b0, 2'b00, 5'h07, 1'b1));
        chk_ready(1'b0, "R4 one to ready ignored");
        w = wait_len(0);
        step(w - 3);
        chk_ready(1'b0, "R2 code0 one edge early");
        chk_sel(1'b1, "R6 reference late in wait");
        step(1);
        chk_ready(1'b1, "R2 code0 at limit");
        chk_sel(1'b0, "R6 pll selected after wait");

        // R2: code 1 and code 3
        for (int c = 1; c <= 3; c += 2) begin
            wr(reg_word(1'b0, 2'(c), 5'(c + 8), 1'b0));
            w = wait_len(c);
            step(w - 1);
            chk_ready(1'b0, $sformatf("R2 code%0d one edge early", c));
            step(1);
            chk_ready(1'b1, $sformatf("R2 code%0d at limit", c));
        end

        // R8: bypass 1->0 together with mode change
        wr(reg_word(1'b1, 2'b00, 5'h0B, 1'b0));
        chk_sel(1'b1, "R7 bypass set immediate");
        wr(reg_word(1'b0, 2'b00, 5'h12, 1'b0));
        chk_ready(1'b0, "R8 combined write starts wait");
        chk_sel(1'b1, "R8 reference at wait start");
        w = wait_len(0);
        step(w - 1);
        chk_sel(1'b1, "R8 reference one edge early");
        step(1);
        chk_sel(1'b0, "R8 pll after full wait");

        // R8: bypass 0->1 together with mode change still waits
        wr(reg_word(1'b1, 2'b00, 5'h13, 1'b0));
        rd(d);
        e = reg_word(1'b1, 2'b00, 5'h13, 1'b0);
        check(d === e, "R8 bypass request stored, ready low", d, e);
        step(w - 1);
        chk_ready(1'b0, "R8 wait before bypass");
        step(1);
        chk_ready(1'b1, "R8 wait done");
        chk_sel(1'b1, "R8 bypass effective");

        // R10: shrink wait-mode in the middle of a code-2 count
        wr(reg_word(1'b0, 2'b10, 5'h02, 1'b0));
        step(1998);
        chk_ready(1'b0, "R10 mid count still low");
        @(negedge clk);
        wr_en = 1'b1;
        wdata = reg_word(1'b0, 2'b00, 5'h02, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
        chk_ready(1'b0, "R10 write edge uses old limit");
        step(1);
        chk_ready(1'b1, "R10 new limit applies");

        // R9: saturation over a long idle time
        step(20000);
        chk_ready(1'b1, "R9 ready held");

        // Random writes that keep the PLL mode
        for (int i = 0; i < 40; i++) begin
            byp = 1'($urandom);
            wm  = 2'($urandom);
            d   = $urandom;
            d[4:0] = 5'h02;
            d[6:5] = wm;
            d[7]   = byp;
            wr(d);
            rd(d);
            e = reg_word(byp, wm, 5'h02, 1'b1);
            check(d === e, "R3 R9 random readback", d, e);
            chk_sel(byp, "R7 random select");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule